// File: doc/BRIEF.md
# Character matrix fetch sequencer

This block decides, one clock at a time, which memory byte a text-mode display must read. Inside the display window it alternates between two kinds of read. On one cycle it reads a character code from the video matrix. On the next cycle it reads the glyph row for that code from the character generator. Outside the window it places a fixed idle address on the bus.

A raster timing unit supplies the horizontal and vertical position, together with strobes that mark the last cycle of a line and the last cycle of a field. Configuration fields set where the window starts (a row position and a column position), how many character columns and rows it holds, and whether characters are 8 or 16 lines tall. The memory returns a data byte and a colour nibble in the same cycle as the address. The block keeps the code and the colour so that the following glyph read and the pixel logic can use them.

The window opens through two sticky latches. The column count and the row count are sampled a fixed number of cycles after the window opens, and the row count is sampled only once per field. The matrix read position moves forward only when the last glyph line of a character row is fetched, so every line of a character row reads the same codes.

Top module: `charfetch_seq`

## Requirements
- R1: While reset is held, `fetchAddr` is 0x1C, and `columnActive`, `charCode` and `charColour` are all zero.
- R2: At each clock edge the vertical latch sets if `firstRow` equals the vertical count of the previous cycle shifted right by one. Once set, it stays set for the rest of the field, even if `firstRow` changes. If `firstRow` is never matched, no fetch happens in that field.
- R3: In a cycle k, the window opens if the vertical latch is set (or is being set in that cycle), `hCount` equals `firstCol`, and the window has not yet opened on this line. When that happens, the matrix counter loads from the base counter and the first matrix fetch appears in cycle k+4.
- R4: `numCols` is sampled in cycle k+1. `numRows` is sampled in cycle k+2, but only on the first window line of a field. Fetching starts in cycle k+4 only if the current character row is below the sampled row count and the sampled column count is nonzero.
- R5: A fetch run lasts 2×columns cycles, with `columnActive` high for the whole run. Steps are numbered from 0. On an even step the address is `matrixBase` plus the matrix counter, and the counter then increments. On an odd step the address is `charBase` plus the code times 8 (times 16 when `tallChars` is 1) plus the glyph line. Every address is kept to 14 bits, with carries dropped.
- R6: On each even step, `charCode` and `charColour` capture `fetchData` and `colourData`. They hold their values at all other times.
- R7: An even step on the last glyph line (7, or 15 when tall) loads the base counter with the incremented matrix counter, so the next character row starts after the codes just read.
- R8: At a `lineEnd` edge on a line where the window opened, the glyph line advances. It wraps after 7 (or 15 when tall), and on that wrap the character row increments. Any `lineEnd` edge also ends a fetch run and re-arms window opening for the next line.
- R9: At a `fieldEnd` edge, the row, the glyph line and the base counter clear to zero, the vertical latch clears, and the row count becomes unsampled.
- R10: In any cycle without an active fetch, `fetchAddr` is 0x1C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one display cycle per edge |
| rstN | input | 1 | Active-low synchronous reset |
| hCount | input | 8 | Horizontal position in the line |
| vCount | input | 9 | Vertical position in the field |
| lineEnd | input | 1 | High in the last cycle of a line |
| fieldEnd | input | 1 | High in the last cycle of a field |
| firstRow | input | 8 | Window start row, compared with the vertical count halved |
| firstCol | input | 7 | Window start horizontal position |
| numCols | input | 7 | Character columns per line |
| numRows | input | 6 | Character rows per field |
| tallChars | input | 1 | 1 selects 16-line characters, 0 selects 8-line |
| matrixBase | input | 14 | Video matrix start address |
| charBase | input | 14 | Character generator start address |
| fetchData | input | 8 | Byte returned for the current address |
| colourData | input | 4 | Colour nibble returned with the byte |
| fetchAddr | output | 14 | Memory address for this cycle |
| charCode | output | 8 | Last character code fetched |
| charColour | output | 4 | Colour nibble of that code |
| columnActive | output | 1 | High while a column fetch runs |

## Verification
The bench runs four fields, each with a different set of configuration values. The first field uses short characters with two rows. This shows the row limit cutting fetching off part way through the window, and the base counter moving forward on the last glyph line. The second field uses tall characters, where the matrix position must hold for sixteen lines, and it starts from a base counter that must have been cleared at the end of the previous field. The third field changes `numRows` and `firstRow` partway through; the result separates a once-per-field row sample and a sticky latch from a design that samples every line. The last field never matches the start row, so every cycle must show the idle address. The memory model makes code, colour and glyph addresses depend on one another, so an error in any of them shows up in the following address.

// File: rtl/charfetch_pkg.sv
package charfetch_pkg;
  // strobes from control to datapath, all valid in the current cycle
  typedef struct packed {
    logic loadMat;    // window opens: matrix counter takes base
    logic evenStep;   // matrix read this cycle
    logic oddStep;    // glyph read this cycle
    logic lastGlyph;  // current glyph line is the last of the cell
    logic clearBase;  // field ends at this edge
  } fetchStrobes_t;

  localparam int GLYPH_W = 4;
endpackage

// File: rtl/charfetch_ctrl.sv
module charfetch_ctrl
  import charfetch_pkg::*;
#(
  parameter int HC_W   = 8,
  parameter int VC_W   = 9,
  parameter int ROW_W  = 8,
  parameter int COLS_W = 7,
  parameter int ROWS_W = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [HC_W-1:0]      hCount,
  input  logic [VC_W-1:0]      vCount,
  input  logic                 lineEnd,
  input  logic                 fieldEnd,
  input  logic [ROW_W-1:0]     firstRow,
  input  logic [COLS_W-1:0]    firstCol,
  input  logic [COLS_W-1:0]    numCols,
  input  logic [ROWS_W-1:0]    numRows,
  input  logic                 tallChars,
  output fetchStrobes_t        strb,
  output logic [GLYPH_W-1:0]   glyph,
  output logic                 columnActive
);
  localparam int CNT_W = COLS_W + 1;
  localparam int RCNT_W = ROWS_W + 1;
  localparam logic [GLYPH_W-1:0] SHORT_LAST = GLYPH_W'(7);
  localparam logic [GLYPH_W-1:0] TALL_LAST  = GLYPH_W'(15);

  logic [VC_W-1:0]   vPrev;
  logic              vLatch, hLatch;
  logic              lcRun;
  logic [1:0]        lcStep;
  logic [COLS_W-1:0] colsLat;
  logic [ROWS_W-1:0] rowsLat;
  logic              rowsValid;
  logic              fetchOn;
  logic [CNT_W-1:0]  colCnt;
  logic [RCNT_W-1:0] row;

  logic vSet, vNow, hit, start, lastG, runLast, rowOk;

  always_comb begin
    vSet    = (VC_W'(firstRow) == (vPrev >> 1));
    vNow    = vLatch | vSet;
    hit     = vNow && (HC_W'(firstCol) == hCount);
    start   = hit && !hLatch;
    lastG   = tallChars ? (glyph == TALL_LAST) : (glyph == SHORT_LAST);
    runLast = (colCnt == ({colsLat, 1'b0} - CNT_W'(1)));
    rowOk   = (row < RCNT_W'(rowsLat)) && (colsLat != '0);
  end

  always_comb begin
    strb.loadMat   = start;
    strb.evenStep  = fetchOn && !colCnt[0];
    strb.oddStep   = fetchOn && colCnt[0];
    strb.lastGlyph = lastG;
    strb.clearBase = fieldEnd;
  end

  assign columnActive = fetchOn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vPrev     <= '0;
      vLatch    <= 1'b0;
      hLatch    <= 1'b0;
      lcRun     <= 1'b0;
      lcStep    <= '0;
      colsLat   <= '0;
      rowsLat   <= '0;
      rowsValid <= 1'b0;
      fetchOn   <= 1'b0;
      colCnt    <= '0;
      row       <= '0;
      glyph     <= '0;
    end else begin
      vPrev  <= vCount;
      vLatch <= vNow;
      hLatch <= hLatch | hit;

      // fetch run progress
      if (fetchOn) begin
        colCnt <= colCnt + CNT_W'(1);
        if (runLast) fetchOn <= 1'b0;
      end

      // sampling sequence after the window opens
      if (start) begin
        lcRun  <= 1'b1;
        lcStep <= 2'd1;
      end else if (lcRun) begin
        case (lcStep)
          2'd1: begin
            colsLat <= numCols;
            lcStep  <= 2'd2;
          end
          2'd2: begin
            if (!rowsValid) begin
              rowsLat   <= numRows;
              rowsValid <= 1'b1;
            end
            lcStep <= 2'd3;
          end
          default: begin
            fetchOn <= rowOk;
            colCnt  <= '0;
            lcRun   <= 1'b0;
          end
        endcase
      end

      // end of line
      if (lineEnd) begin
        hLatch  <= 1'b0;
        lcRun   <= 1'b0;
        fetchOn <= 1'b0;
        if (hLatch || hit) begin
          if (lastG) begin
            glyph <= '0;
            row   <= row + RCNT_W'(1);
          end else begin
            glyph <= glyph + GLYPH_W'(1);
          end
        end
      end

      // end of field overrides line effects
      if (fieldEnd) begin
        vLatch    <= 1'b0;
        rowsValid <= 1'b0;
        row       <= '0;
        glyph     <= '0;
      end
    end
  end
endmodule

// File: rtl/charfetch_datapath.sv
module charfetch_datapath
  import charfetch_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int CODE_W = 8,
  parameter int CLR_W  = 4,
  parameter logic [ADDR_W-1:0] IDLE_ADDR = ADDR_W'(28)
) (
  input  logic               clk,
  input  logic               rstN,
  input  fetchStrobes_t      strb,
  input  logic               tallChars,
  input  logic [GLYPH_W-1:0] glyph,
  input  logic [ADDR_W-1:0]  matrixBase,
  input  logic [ADDR_W-1:0]  charBase,
  input  logic [CODE_W-1:0]  fetchData,
  input  logic [CLR_W-1:0]   colourData,
  output logic [ADDR_W-1:0]  fetchAddr,
  output logic [CODE_W-1:0]  charCode,
  output logic [CLR_W-1:0]   charColour
);
  logic [ADDR_W-1:0] matCnt, baseCnt;
  logic [ADDR_W-1:0] matNext, glyphAddr, cellOfs;

  always_comb begin
    matNext   = matCnt + ADDR_W'(1);
    cellOfs   = tallChars ? (ADDR_W'(charCode) << 4) : (ADDR_W'(charCode) << 3);
    glyphAddr = charBase + cellOfs + ADDR_W'(glyph);
    if (strb.evenStep)     fetchAddr = matrixBase + matCnt;
    else if (strb.oddStep) fetchAddr = glyphAddr;
    else                   fetchAddr = IDLE_ADDR;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      matCnt     <= '0;
      baseCnt    <= '0;
      charCode   <= '0;
      charColour <= '0;
    end else begin
      if (strb.loadMat) matCnt <= baseCnt;
      else if (strb.evenStep) matCnt <= matNext;

      if (strb.evenStep) begin
        charCode   <= fetchData;
        charColour <= colourData;
      end

      if (strb.clearBase) baseCnt <= '0;
      else if (strb.evenStep && strb.lastGlyph) baseCnt <= matNext;
    end
  end
endmodule

// File: rtl/charfetch_seq.sv
module charfetch_seq
  import charfetch_pkg::*;
#(
  parameter int HC_W   = 8,
  parameter int VC_W   = 9,
  parameter int ROW_W  = 8,
  parameter int COLS_W = 7,
  parameter int ROWS_W = 6,
  parameter int ADDR_W = 14,
  parameter int CODE_W = 8,
  parameter int CLR_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [HC_W-1:0]   hCount,
  input  logic [VC_W-1:0]   vCount,
  input  logic              lineEnd,
  input  logic              fieldEnd,
  input  logic [ROW_W-1:0]  firstRow,
  input  logic [COLS_W-1:0] firstCol,
  input  logic [COLS_W-1:0] numCols,
  input  logic [ROWS_W-1:0] numRows,
  input  logic              tallChars,
  input  logic [ADDR_W-1:0] matrixBase,
  input  logic [ADDR_W-1:0] charBase,
  input  logic [CODE_W-1:0] fetchData,
  input  logic [CLR_W-1:0]  colourData,
  output logic [ADDR_W-1:0] fetchAddr,
  output logic [CODE_W-1:0] charCode,
  output logic [CLR_W-1:0]  charColour,
  output logic              columnActive
);
  fetchStrobes_t      strb;
  logic [GLYPH_W-1:0] glyph;

  charfetch_ctrl #(
    .HC_W(HC_W), .VC_W(VC_W), .ROW_W(ROW_W), .COLS_W(COLS_W), .ROWS_W(ROWS_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .hCount(hCount), .vCount(vCount),
    .lineEnd(lineEnd), .fieldEnd(fieldEnd), .firstRow(firstRow),
    .firstCol(firstCol), .numCols(numCols), .numRows(numRows),
    .tallChars(tallChars), .strb(strb), .glyph(glyph),
    .columnActive(columnActive)
  );

  charfetch_datapath #(
    .ADDR_W(ADDR_W), .CODE_W(CODE_W), .CLR_W(CLR_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .tallChars(tallChars),
    .glyph(glyph), .matrixBase(matrixBase), .charBase(charBase),
    .fetchData(fetchData), .colourData(colourData),
    .fetchAddr(fetchAddr), .charCode(charCode), .charColour(charColour)
  );
endmodule

// File: rtl/charfetch_checks.sv
module charfetch_checks #(
  parameter int ADDR_W = 14,
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              lineEnd,
  input logic              columnActive,
  input logic [ADDR_W-1:0] fetchAddr,
  input logic [CODE_W-1:0] charCode,
  input logic [CODE_W-1:0] fetchData,
  input logic              evenStep,
  input logic              oddStep
);
  localparam logic [ADDR_W-1:0] IDLE = ADDR_W'(28);

  assert_idle_addr_R10: assert property (@(posedge clk) disable iff (!rstN)
    !columnActive |-> fetchAddr == IDLE);

  assert_odd_after_even_R5: assert property (@(posedge clk) disable iff (!rstN)
    oddStep |-> $past(evenStep));

  assert_code_capture_R6: assert property (@(posedge clk) disable iff (!rstN)
    evenStep |=> charCode == $past(fetchData));

  assert_code_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !columnActive |=> $stable(charCode));

  assert_line_stops_run_R8: assert property (@(posedge clk) disable iff (!rstN)
    lineEnd |=> !columnActive);
endmodule

bind charfetch_seq charfetch_checks #(.ADDR_W(ADDR_W), .CODE_W(CODE_W)) u_checks (
  .clk(clk), .rstN(rstN), .lineEnd(lineEnd), .columnActive(columnActive),
  .fetchAddr(fetchAddr), .charCode(charCode), .fetchData(fetchData),
  .evenStep(strb.evenStep), .oddStep(strb.oddStep)
);

// File: tb/charfetch_seq_test.sv
module charfetch_seq_test;
  localparam int LINE_LEN = 24;
  localparam int FIELD_LINES = 30;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rstN;
  logic [7:0]  hCount;
  logic [8:0]  vCount;
  logic        lineEnd, fieldEnd;
  logic [7:0]  firstRow;
  logic [6:0]  firstCol, numCols;
  logic [5:0]  numRows;
  logic        tallChars;
  logic [13:0] matrixBase, charBase;
  logic [7:0]  fetchData;
  logic [3:0]  colourData;
  logic [13:0] fetchAddr;
  logic [7:0]  charCode;
  logic [3:0]  charColour;
  logic        columnActive;

  function automatic logic [7:0] dataOf(input logic [13:0] a);
    return a[7:0] ^ 8'h3C ^ {a[13:8], 2'b01};
  endfunction
  function automatic logic [3:0] colOf(input logic [13:0] a);
    return a[3:0] ^ a[7:4] ^ 4'h9;
  endfunction

  assign fetchData  = dataOf(fetchAddr);
  assign colourData = colOf(fetchAddr);

  charfetch_seq uut (
    .clk(clk), .rstN(rstN), .hCount(hCount), .vCount(vCount),
    .lineEnd(lineEnd), .fieldEnd(fieldEnd), .firstRow(firstRow),
    .firstCol(firstCol), .numCols(numCols), .numRows(numRows),
    .tallChars(tallChars), .matrixBase(matrixBase), .charBase(charBase),
    .fetchData(fetchData), .colourData(colourData), .fetchAddr(fetchAddr),
    .charCode(charCode), .charColour(charColour), .columnActive(columnActive)
  );

  typedef struct {
    int addr; bit act; int code; int colour; int vc; int hc;
  } item_t;
  item_t q[$];
  event  sampleEv;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // per-field observations
  int activeCnt, firstActLine, firstActHc;
  int firstMat[FIELD_LINES];
  bit prevAct;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pop expected items and compare with the outputs
  always @(sampleEv) begin
    #2;
    while (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      chk(columnActive == it.act, it.act ? "R5 active" : "R10 active", columnActive, it.act);
      chk(fetchAddr == it.addr[13:0], it.act ? "R5 addr" : "R10 addr", fetchAddr, it.addr);
      chk(charCode == it.code[7:0], "R6 code", charCode, it.code);
      chk(charColour == it.colour[3:0], "R6 colour", charColour, it.colour);
      if (columnActive) begin
        activeCnt++;
        if (firstActLine < 0) begin
          firstActLine = it.vc;
          firstActHc   = it.hc;
        end
        if (!prevAct && firstMat[it.vc] < 0) firstMat[it.vc] = int'(fetchAddr);
      end
      prevAct = columnActive;
    end
  end

  // reference state built from the requirements
  int mPrevV, mRows, mCols, mRow, mGlyph, mBase, mMat, mCode, mColour, mColCnt, mLc;
  bit mV, mH, mRun, mRowsV, mFetch;

  task automatic stepCycle(input int vc, input int hc);
    bit vSet, hit, lastG, oFetch, oH;
    int expAddr, oMat, glyphTop;
    @(negedge clk);
    hCount   = 8'(hc);
    vCount   = 9'(vc);
    lineEnd  = (hc == LINE_LEN - 1);
    fieldEnd = lineEnd && (vc == FIELD_LINES - 1);
    vSet = (int'(firstRow) == (mPrevV >> 1));
    hit  = (mV || vSet) && (hc == int'(firstCol)) && !mH;
    glyphTop = tallChars ? 15 : 7;
    lastG = (mGlyph == glyphTop);
    if (mFetch) begin
      if ((mColCnt % 2) == 0) expAddr = (int'(matrixBase) + mMat) & 16'h3FFF;
      else expAddr = (int'(charBase) + mCode * (tallChars ? 16 : 8) + mGlyph) & 16'h3FFF;
    end else expAddr = 28;
    q.push_back('{expAddr, mFetch, mCode, mColour, vc, hc});
    -> sampleEv;
    @(posedge clk);
    oMat = mMat; oFetch = mFetch; oH = mH;
    if (oFetch && (mColCnt % 2) == 0) begin
      mCode   = int'(dataOf(14'(expAddr)));
      mColour = int'(colOf(14'(expAddr)));
      mMat    = oMat + 1;
      if (lastG) mBase = oMat + 1;
    end
    if (hit) mMat = mBase;
    if (oFetch) begin
      if (mColCnt == 2 * mCols - 1) mFetch = 1'b0;
      mColCnt++;
    end
    if (hit) begin
      mRun = 1'b1; mLc = 1;
    end else if (mRun) begin
      if (mLc == 1) begin
        mCols = int'(numCols); mLc = 2;
      end else if (mLc == 2) begin
        if (!mRowsV) begin mRows = int'(numRows); mRowsV = 1'b1; end
        mLc = 3;
      end else begin
        mFetch = (mRow < mRows) && (mCols != 0);
        mColCnt = 0; mRun = 1'b0;
      end
    end
    mV = mV || vSet;
    mH = oH || hit;
    if (lineEnd) begin
      if (oH || hit) begin
        if (lastG) begin mGlyph = 0; mRow++; end
        else mGlyph = (mGlyph + 1) % 16;
      end
      mH = 1'b0; mRun = 1'b0; mFetch = 1'b0;
    end
    if (fieldEnd) begin
      mRow = 0; mGlyph = 0; mBase = 0; mV = 1'b0; mRowsV = 1'b0;
    end
    mPrevV = vc;
  endtask

  task automatic runField(input int fieldIdx);
    activeCnt = 0; firstActLine = -1; firstActHc = -1; prevAct = 1'b0;
    for (int i = 0; i < FIELD_LINES; i++) firstMat[i] = -1;
    for (int v = 0; v < FIELD_LINES; v++) begin
      if (fieldIdx == 2 && v == 8) begin
        // mid-field changes: row count and start row must have no effect now
        @(negedge clk);
        numRows  = 6'd3;
        firstRow = 8'd20;
      end
      for (int h = 0; h < LINE_LEN; h++) stepCycle(v, h);
    end
    @(negedge clk);
    #3;
  endtask

  initial begin
    rstN = 1'b0; hCount = '0; vCount = '0; lineEnd = 1'b0; fieldEnd = 1'b0;
    firstRow = 8'd2; firstCol = 7'd5; numCols = 7'd3; numRows = 6'd2;
    tallChars = 1'b0; matrixBase = 14'h1E00; charBase = 14'h3C00;
    mPrevV = 0; mRows = 0; mCols = 0; mRow = 0; mGlyph = 0; mBase = 0; mMat = 0;
    mCode = 0; mColour = 0; mColCnt = 0; mLc = 0;
    mV = 0; mH = 0; mRun = 0; mRowsV = 0; mFetch = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); #3;
    chk(fetchAddr == 14'h1C, "R1 addr", fetchAddr, 14'h1C);
    chk(columnActive == 1'b0, "R1 active", columnActive, 0);
    chk(charCode == 8'h00, "R1 code", charCode, 0);
    chk(charColour == 4'h0, "R1 colour", charColour, 0);
    rstN = 1'b1;

    // field A: short cells, two rows
    runField(0);
    chk(firstActLine == 4, "R2 first window line", firstActLine, 4);
    chk(firstActHc == 9, "R3 first fetch cycle", firstActHc, 9);
    chk(activeCnt == 96, "R4 row limit active cycles", activeCnt, 96);
    chk(firstMat[11] == 'h1E00, "R8 same row reuses codes", firstMat[11], 'h1E00);
    chk(firstMat[12] == 'h1E03, "R7 base advance", firstMat[12], 'h1E03);
    chk(firstMat[20] == -1, "R4 past last row", firstMat[20], -1);

    // field B: tall cells, one row, two columns
    tallChars = 1'b1; numCols = 7'd2; numRows = 6'd1;
    runField(1);
    chk(firstMat[4] == 'h1E00, "R9 base cleared", firstMat[4], 'h1E00);
    chk(firstMat[19] == 'h1E00, "R8 tall row holds", firstMat[19], 'h1E00);
    chk(activeCnt == 64, "R5 tall run length", activeCnt, 64);

    // field C: row count and start row change mid-field
    tallChars = 1'b0; numCols = 7'd3; numRows = 6'd1; firstRow = 8'd2;
    runField(2);
    chk(activeCnt == 48, "R4 rows sampled once", activeCnt, 48);
    chk(firstMat[9] == 'h1E00, "R2 latch sticky", firstMat[9], 'h1E00);

    // field D: start row never matched
    firstRow = 8'd40;
    runField(3);
    chk(activeCnt == 0, "R2 no match no fetch", activeCnt, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule